// File: doc/BRIEF.md
# ADC Conversion Request Arbiter

This block sits between the request logic of a multi-channel ADC controller and its conversion engine. It accepts three kinds of work: a normal scan that walks every channel enabled in a mask, an injected scan that walks a second mask, and a single hardware-triggered conversion of one channel named by a timing unit. It hands the engine one channel at a time, with a start strobe, and waits for the engine's end-of-conversion strobe before it issues the next channel.

A hardware trigger has the highest rank. If it arrives while a scan channel is being converted, that conversion is abandoned at once: the block raises an abort strobe together with the start of the triggered channel. Once the triggered conversion completes, the interrupted scan picks up again at the channel that was abandoned. Triggers and injected requests that arrive while a triggered conversion is running are dropped. Normal requests made then are kept and served afterwards. Between channels, a pending injected scan is served before a pending normal scan.

Mask bit i enables channel i. Every output is registered.

Top module: `adc_req_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is 0.
- R2: A normal request with a non-zero mask issues every channel whose mask bit is 1, once each, in ascending index order. A normal request with an all-zero mask is ignored and leaves the normal busy flag at 0.
- R3: A trigger accepted while a scan channel is outstanding, with no end-of-conversion in that cycle, produces one cycle with both the abort strobe and the start strobe at 1 and the channel output equal to the trigger channel. A trigger accepted while nothing is outstanding gives a start with the abort strobe at 0.
- R4: After the triggered conversion ends, the interrupted scan issues the aborted channel again, then continues with the rest of its channels.
- R5: A trigger that arrives while the trigger busy flag is 1 is discarded: no start strobe follows and the busy flag is unchanged.
- R6: The trigger busy flag rises in the same cycle as the start strobe of the triggered channel and stays at 1 until the cycle after that conversion's end-of-conversion strobe.
- R7: A normal request made while the trigger busy flag is 1 raises the normal busy flag, and its first channel is issued only after the triggered conversion ends.
- R8: An injected request made while the trigger busy flag is 1 is discarded, and the injected busy flag stays at 0.
- R9: An injected scan issues its enabled channels in ascending order. When both scans are pending at a channel boundary, the injected channel is issued first. The injected end-of-chain output pulses for one cycle after its last channel completes.
- R10: When the last enabled channel of a normal scan completes, the normal busy flag clears and the normal end-of-chain output pulses for exactly one cycle.
- R11: At most one conversion is outstanding. A start strobe without an abort is never issued between a start and its end-of-conversion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_req_i | input | 1 | One-cycle request for a normal scan |
| norm_mask_i | input | NCH | Channel enables for the normal scan, bit i for channel i |
| inj_req_i | input | 1 | One-cycle request for an injected scan |
| inj_mask_i | input | NCH | Channel enables for the injected scan |
| trig_i | input | 1 | One-cycle hardware trigger |
| trig_ch_i | input | CHW | Channel to convert on a trigger |
| eoc_i | input | 1 | End-of-conversion strobe from the engine |
| conv_ch_o | output | CHW | Channel to convert, valid with conv_start_o |
| conv_start_o | output | 1 | Start strobe to the engine |
| conv_abort_o | output | 1 | Abandon the outstanding conversion |
| norm_busy_o | output | 1 | Normal scan accepted and not finished |
| inj_busy_o | output | 1 | Injected scan accepted and not finished |
| trig_busy_o | output | 1 | Triggered conversion in progress |
| norm_chain_o | output | 1 | One-cycle pulse at the end of a normal scan |
| inj_chain_o | output | 1 | One-cycle pulse at the end of an injected scan |

## Verification
A cursor that skips or fails to hold its position across a pre-emption shows up in the channel sequence issued to the engine. That sequence diverges from the expected order at the first start after the triggered conversion, which is a few cycles after the abort. A wrong trigger-busy state shows up in the very next cycle as a start strobe that should have been suppressed, or as a dropped scan request. A stale end-of-chain condition shows up as a missing or doubled end-of-chain pulse when the scan drains.

// File: rtl/adc_arb_pkg.sv
package adc_arb_pkg;
    // Which kind of conversion currently occupies the engine
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_NORM = 2'd1,
        ACT_INJ  = 2'd2,
        ACT_TRIG = 2'd3
    } act_e;
endpackage

// File: rtl/adc_arb_scan.sv
// Scan cursor: holds a channel mask and points at the channel to convert.
// The pointer advances only on a completed conversion, so a pre-empted
// channel is re-issued later.
module adc_arb_scan #(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic           en_i,
    input  logic [NCH-1:0] mask_i,
    input  logic           adv_i,
    output logic           busy_o,
    output logic [CHW-1:0] ch_o,
    output logic           done_o
);
    typedef struct packed {
        logic           busy;
        logic [NCH-1:0] mask;
        logic [CHW-1:0] ptr;
        logic           done;
    } scan_st_t;

    scan_st_t s_d, s_q;
    logic           nxt_found_d;
    logic [CHW-1:0] nxt_idx_d;
    logic [CHW-1:0] fst_idx_d;

    // Lowest enabled channel above the current pointer
    always_comb begin
        nxt_found_d = 1'b0;
        nxt_idx_d   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (s_q.mask[i] && (i > int'(s_q.ptr))) begin
                nxt_found_d = 1'b1;
                nxt_idx_d   = CHW'(i);
            end
        end
    end

    // Lowest enabled channel of a fresh request
    always_comb begin
        fst_idx_d = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i]) fst_idx_d = CHW'(i);
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (adv_i && s_q.busy) begin
            if (nxt_found_d) begin
                s_d.ptr = nxt_idx_d;
            end else begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (req_i && en_i && !s_q.busy && (|mask_i)) begin
            s_d.busy = 1'b1;
            s_d.mask = mask_i;
            s_d.ptr  = fst_idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign ch_o   = s_q.ptr;
    assign done_o = s_q.done;

    AST_SCAN_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) && (ch_o != $past(ch_o)) |-> ch_o > $past(ch_o)); // R2
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o)); // R10
endmodule

// File: rtl/adc_req_arbiter.sv
module adc_req_arbiter
    import adc_arb_pkg::*;
#(
    parameter int  NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           norm_req_i,
    input  logic [NCH-1:0] norm_mask_i,
    input  logic           inj_req_i,
    input  logic [NCH-1:0] inj_mask_i,
    input  logic           trig_i,
    input  logic [CHW-1:0] trig_ch_i,
    input  logic           eoc_i,
    output logic [CHW-1:0] conv_ch_o,
    output logic           conv_start_o,
    output logic           conv_abort_o,
    output logic           norm_busy_o,
    output logic           inj_busy_o,
    output logic           trig_busy_o,
    output logic           norm_chain_o,
    output logic           inj_chain_o
);
    typedef struct packed {
        act_e           act;
        logic           trig;
        logic [CHW-1:0] ch;
        logic           start;
        logic           abort;
    } arb_st_t;

    arb_st_t s_d, s_q;

    logic           norm_adv, inj_adv;
    logic [CHW-1:0] norm_ch, inj_ch;

    // A completed conversion moves the owning cursor on; an aborted one does not
    assign norm_adv = eoc_i && (s_q.act == ACT_NORM);
    assign inj_adv  = eoc_i && (s_q.act == ACT_INJ);

    adc_arb_scan #(.NCH(NCH), .CHW(CHW)) i_norm_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (norm_req_i),
        .en_i   (1'b1),
        .mask_i (norm_mask_i),
        .adv_i  (norm_adv),
        .busy_o (norm_busy_o),
        .ch_o   (norm_ch),
        .done_o (norm_chain_o)
    );

    // Injected requests are refused while a triggered conversion runs
    adc_arb_scan #(.NCH(NCH), .CHW(CHW)) i_inj_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (inj_req_i),
        .en_i   (!s_q.trig),
        .mask_i (inj_mask_i),
        .adv_i  (inj_adv),
        .busy_o (inj_busy_o),
        .ch_o   (inj_ch),
        .done_o (inj_chain_o)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.abort = 1'b0;
        if (eoc_i && (s_q.act != ACT_IDLE)) begin
            s_d.act  = ACT_IDLE;
            s_d.trig = 1'b0;
        end
        if (trig_i && !s_q.trig) begin
            s_d.trig  = 1'b1;
            s_d.act   = ACT_TRIG;
            s_d.ch    = trig_ch_i;
            s_d.start = 1'b1;
            s_d.abort = ((s_q.act == ACT_NORM) || (s_q.act == ACT_INJ)) && !eoc_i;
        end else if (s_q.act == ACT_IDLE) begin
            if (inj_busy_o) begin
                s_d.act   = ACT_INJ;
                s_d.ch    = inj_ch;
                s_d.start = 1'b1;
            end else if (norm_busy_o) begin
                s_d.act   = ACT_NORM;
                s_d.ch    = norm_ch;
                s_d.start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{act: ACT_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign conv_ch_o    = s_q.ch;
    assign conv_start_o = s_q.start;
    assign conv_abort_o = s_q.abort;
    assign trig_busy_o  = s_q.trig;

    // Tracks an issued conversion awaiting its end strobe (checking only)
    logic pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= 1'b0;
        else if (conv_start_o) pend_q <= 1'b1;
        else if (eoc_i)        pend_q <= 1'b0;
    end

    AST_ABORT_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort_o |-> conv_start_o && trig_busy_o); // R3
    AST_TRIG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        trig_busy_o && !eoc_i |=> trig_busy_o && !conv_start_o); // R5
    AST_TRIG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_busy_o) |-> conv_start_o && (conv_ch_o == $past(trig_ch_i))); // R6
    AST_INJ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        trig_busy_o && !inj_busy_o |=> !inj_busy_o); // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o && !conv_abort_o |-> !pend_q); // R11
endmodule

// File: tb/test_adc_req_arbiter.sv
`timescale 1ns/1ps
module test_adc_req_arbiter;
    localparam int NCH = 8;
    localparam int CHW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           norm_req_i = 1'b0;
    logic [NCH-1:0] norm_mask_i = '0;
    logic           inj_req_i = 1'b0;
    logic [NCH-1:0] inj_mask_i = '0;
    logic           trig_i = 1'b0;
    logic [CHW-1:0] trig_ch_i = '0;
    logic           eoc_i = 1'b0;
    logic [CHW-1:0] conv_ch_o;
    logic           conv_start_o, conv_abort_o;
    logic           norm_busy_o, inj_busy_o, trig_busy_o;
    logic           norm_chain_o, inj_chain_o;

    adc_req_arbiter #(.NCH(NCH)) i_adc_req_arbiter (
        .clk(clk), .rst_n(rst_n),
        .norm_req_i(norm_req_i), .norm_mask_i(norm_mask_i),
        .inj_req_i(inj_req_i), .inj_mask_i(inj_mask_i),
        .trig_i(trig_i), .trig_ch_i(trig_ch_i), .eoc_i(eoc_i),
        .conv_ch_o(conv_ch_o), .conv_start_o(conv_start_o), .conv_abort_o(conv_abort_o),
        .norm_busy_o(norm_busy_o), .inj_busy_o(inj_busy_o), .trig_busy_o(trig_busy_o),
        .norm_chain_o(norm_chain_o), .inj_chain_o(inj_chain_o)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Engine model and monitor
    int lat = 3;
    int rem = 0;
    int log_n = 0;
    int log_ch [64];
    int log_ab [64];
    int chains = 0;
    int ichains = 0;
    int overlap = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            rem   = 0;
            eoc_i = 1'b0;
        end else begin
            eoc_i = 1'b0;
            if (conv_start_o) begin
                if (rem > 0 && !conv_abort_o) overlap++;
                if (log_n < 64) begin
                    log_ch[log_n] = int'(conv_ch_o);
                    log_ab[log_n] = int'(conv_abort_o);
                end
                log_n++;
                rem = lat;
            end else if (rem > 0) begin
                rem--;
                if (rem == 0) eoc_i = 1'b1;
            end
            if (norm_chain_o) chains++;
            if (inj_chain_o) ichains++;
        end
    end

    // Expected sequence
    int exp_ch [64];
    int exp_ab [64];
    int exp_n = 0;

    function automatic int mask_len(input logic [NCH-1:0] m);
        int n = 0;
        for (int i = 0; i < NCH; i++) if (m[i]) n++;
        return n;
    endfunction

    // Channel at position p of the ascending list for mask m
    function automatic int mask_at(input logic [NCH-1:0] m, input int p);
        int n = 0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                if (n == p) return i;
                n++;
            end
        end
        return -1;
    endfunction

    task automatic push(input int ch, input int ab);
        exp_ch[exp_n] = ch;
        exp_ab[exp_n] = ab;
        exp_n++;
    endtask

    task automatic push_range(input logic [NCH-1:0] m, input int lo, input int hi);
        for (int p = lo; p <= hi; p++) push(mask_at(m, p), 0);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_log(input string tag);
        int bad = -1;
        if (log_n == exp_n) begin
            for (int i = 0; i < exp_n; i++)
                if (bad < 0 && (log_ch[i] != exp_ch[i] || log_ab[i] != exp_ab[i])) bad = i;
        end
        if (log_n != exp_n) check(1'b0, {tag, " sequence length"}, log_n, exp_n);
        else if (bad >= 0) check(1'b0, {tag, " channel/abort at entry"},
                                 log_ch[bad] * 10 + log_ab[bad], exp_ch[bad] * 10 + exp_ab[bad]);
        else check(1'b1, tag, 0, 0);
    endtask

    task automatic clear_scoreboard();
        log_n = 0; exp_n = 0; chains = 0; ichains = 0;
    endtask

    task automatic wait_idle();
        int t = 0;
        do begin
            @(negedge clk);
            t++;
        end while ((norm_busy_o || inj_busy_o || trig_busy_o || rem > 0) && t < 3000);
        repeat (3) @(negedge clk);
        if (t >= 3000) check(1'b0, "idle timeout", t, 3000);
    endtask

    task automatic wait_log(input int target);
        int t = 0;
        while (log_n < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic pulse_trig(input int ch);
        trig_ch_i = CHW'(ch);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    task automatic plain_scan(input logic [NCH-1:0] m);
        clear_scoreboard();
        push_range(m, 0, mask_len(m) - 1);
        norm_mask_i = m;
        norm_req_i = 1'b1;
        @(negedge clk);
        norm_req_i = 1'b0;
        wait_idle();
        compare_log("R2 ascending scan");
        check(chains == 1 && !norm_busy_o, "R10 one end-of-chain pulse", chains, 1);
    endtask

    task automatic trig_scan(input logic [NCH-1:0] m, input int k, input int x,
                             input bit second, input int y);
        clear_scoreboard();
        push_range(m, 0, k);
        push(x, 1);
        push_range(m, k, mask_len(m) - 1);
        norm_mask_i = m;
        norm_req_i = 1'b1;
        @(negedge clk);
        norm_req_i = 1'b0;
        wait_log(k + 1);
        @(negedge clk);
        pulse_trig(x);
        check(conv_start_o && conv_abort_o && int'(conv_ch_o) == x,
              "R3 abort with triggered start", int'(conv_ch_o), x);
        check(trig_busy_o == 1'b1, "R6 trigger busy with start", int'(trig_busy_o), 1);
        if (second) begin
            @(negedge clk);
            pulse_trig(y);
            check(!conv_start_o && trig_busy_o, "R5 second trigger discarded",
                  int'(conv_start_o), 0);
        end
        wait_idle();
        compare_log("R4 resume at aborted channel");
        check(chains == 1, "R10 chain after pre-empted scan", chains, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!conv_start_o && !conv_abort_o && conv_ch_o == '0 && !norm_busy_o &&
              !inj_busy_o && !trig_busy_o && !norm_chain_o && !inj_chain_o,
              "R1 outputs in reset", int'(conv_start_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!conv_start_o && !norm_busy_o && !trig_busy_o && !inj_busy_o,
              "R1 outputs after reset", int'(norm_busy_o), 0);

        // Directed: full, single, edges
        lat = 3;
        plain_scan(8'hFF);
        plain_scan(8'h80);
        plain_scan(8'h81);

        // R2: zero mask ignored
        clear_scoreboard();
        norm_mask_i = '0;
        norm_req_i = 1'b1;
        @(negedge clk);
        norm_req_i = 1'b0;
        repeat (4) @(negedge clk);
        check(!norm_busy_o && log_n == 0, "R2 zero mask ignored", log_n, 0);

        // Directed pre-emption on first and last channel, with a second trigger
        lat = 5;
        trig_scan(8'b1010_0110, 0, 7, 1'b1, 2);
        trig_scan(8'b1010_0110, 3, 0, 1'b1, 5);

        // R7 / R8: requests during a triggered conversion from idle
        lat = 6;
        clear_scoreboard();
        push(4, 0);
        push_range(8'b0011_0001, 0, 2);
        pulse_trig(4);
        check(conv_start_o && !conv_abort_o && int'(conv_ch_o) == 4,
              "R3 idle trigger starts without abort", int'(conv_abort_o), 0);
        norm_mask_i = 8'b0011_0001;
        norm_req_i = 1'b1;
        @(negedge clk);
        norm_req_i = 1'b0;
        check(norm_busy_o && log_n == 1, "R7 normal request held pending", log_n, 1);
        inj_mask_i = 8'h0F;
        inj_req_i = 1'b1;
        @(negedge clk);
        inj_req_i = 1'b0;
        check(!inj_busy_o, "R8 injected request discarded", int'(inj_busy_o), 0);
        wait_idle();
        compare_log("R7 pending scan starts after trigger");
        check(ichains == 0, "R8 no injected chain", ichains, 0);

        // R9: injected alone, then both at once
        lat = 2;
        clear_scoreboard();
        push_range(8'b0100_1010, 0, 2);
        inj_mask_i = 8'b0100_1010;
        inj_req_i = 1'b1;
        @(negedge clk);
        inj_req_i = 1'b0;
        wait_idle();
        compare_log("R9 injected ascending scan");
        check(ichains == 1 && !inj_busy_o, "R9 injected end-of-chain", ichains, 1);

        clear_scoreboard();
        push_range(8'b1000_0100, 0, 1);
        push_range(8'b0001_0011, 0, 2);
        inj_mask_i = 8'b1000_0100;
        norm_mask_i = 8'b0001_0011;
        inj_req_i = 1'b1;
        norm_req_i = 1'b1;
        @(negedge clk);
        inj_req_i = 1'b0;
        norm_req_i = 1'b0;
        wait_idle();
        compare_log("R9 injected before normal");

        // Constrained random
        for (int it = 0; it < 16; it++) begin
            logic [NCH-1:0] m;
            int len;
            m = NCH'($urandom);
            if (m == '0) m = 8'h01;
            len = mask_len(m);
            lat = 3 + int'($urandom % 4);
            if (it % 3 == 0) plain_scan(m);
            else trig_scan(m, int'($urandom % len), int'($urandom % NCH),
                           bit'($urandom % 2), int'($urandom % NCH));
        end

        check(overlap == 0, "R11 no overlapping conversions", overlap, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule